// File: doc/BRIEF.md
# Ternary CAM search core

This block is a small associative lookup table of 64-bit words, sized by parameter (64 words by default), intended for network address filtering. Every word has a two-bit kind tag. A search key is matched in parallel against all words of one kind. The block reports whether any word hit, whether more than one word hit, and the lowest hit address. A global don't-care mask can remove bit positions from the search, and only a selectable number of low 16-bit segments takes part in it. The remaining upper segments hold associated data that is stored but never searched.

The block is driven by one command per clock through `cmd_op`. Writes can target an absolute address, the last hit address or the lowest free word. Each write can be filtered through the same mask, so that masked bits keep their old value. The mask can be loaded or shifted by one position. Search results are held in registers until the next search. The free-slot outputs follow the kind tags one cycle after each command.

Top module: `tcam_search_core`

## Requirements
- R1: Each word has a kind tag {skip,empty}. 2'b00 is Valid, 2'b01 is Empty, 2'b10 is Skip and 2'b11 is RAM. A write stores `cmd_kind` as the new tag of the target word.
- R2: `cmd_op`=2 (load key) stores `cmd_data` as the key and searches only Valid words. `cmd_op`=3 (forced search) searches the stored key against words whose tag equals `cmd_kind`.
- R3: During a search with `cmd_use_mask`=1, every bit set in the mask register is ignored in every word. With `cmd_use_mask`=0, all bits in the compared field count.
- R4: `match_addr_o` is the lowest address among the hit words. It is 0 when nothing hits, and `match_o` is high when at least one word hits.
- R5: `multi_o` is high exactly when two or more words hit in the last search.
- R6: With `cmp_segs`=n, only bits [16*(n+1)-1:0] of the key and the words take part in a search. Upper bits never affect a search.
- R7: One cycle after any command, `free_addr_o` is the lowest address tagged Empty. `full_o` is high, with `free_addr_o`=0, when no Empty word is left.
- R8: `match_o`, `multi_o` and `match_addr_o` change only in the cycle after a search command (op 2 or 3).
- R9: Reset tags every word Empty and clears the key, the mask, all flags and both addresses.
- R10: `cmd_op`=1 writes `cmd_data`. With `cmd_amode`=0 it writes to `cmd_addr`. With `cmd_amode`=1 it writes to the last hit address and is ignored if `match_o` is low. With `cmd_amode`=2 it writes to `free_addr_o` and is ignored if `full_o` is high. With `cmd_amode`=3 nothing is written.
- R11: In a write with `cmd_use_mask`=1, every bit set in the mask register keeps the old value of the target word.
- R12: `cmd_op`=4 loads the mask from `cmd_data`. Op 5 shifts the mask left by one, and op 6 shifts it right by one, both with zero fill. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 3 | Command: 0 none, 1 write, 2 load key and search, 3 forced search, 4 load mask, 5 mask left, 6 mask right |
| cmd_amode | input | 2 | Write target: 0 absolute, 1 hit address, 2 free address, 3 none |
| cmd_addr | input | AW | Absolute write address |
| cmd_data | input | WIDTH | Write data, key or mask value |
| cmd_kind | input | 2 | Tag for writes, target tag for forced search |
| cmd_use_mask | input | 1 | Apply the mask to this search or write |
| cmp_segs | input | SEL_W | Number of compared 16-bit segments minus one |
| match_o | output | 1 | At least one word hit |
| multi_o | output | 1 | Two or more words hit |
| match_addr_o | output | AW | Lowest hit address |
| full_o | output | 1 | No Empty word left |
| free_addr_o | output | AW | Lowest Empty address |

## Verification
Directed searches first use a single hit, then duplicate keys, then keys that sit only in Skip or RAM words. This separates the lowest-address rule, the multiple-hit flag and the kind filter of automatic and forced searches. Keys are then varied in masked, unmasked and upper-segment bit positions, before and after the mask is shifted. This shows whether the mask and the segment count each remove exactly their bits. Writes are aimed at the hit address, at the free address and into a full table, and their effect is read back by searching. A long random phase then mixes all commands with keys drawn from a small pool, with single bits flipped, so that hits, misses and duplicate hits all occur often. A behavioural table model predicts every result.

// File: rtl/tcam_pkg.sv
`timescale 1ns/1ps
package tcam_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_WRITE     = 3'd1,
        OP_LOAD_KEY  = 3'd2,
        OP_FORCE     = 3'd3,
        OP_LOAD_MASK = 3'd4,
        OP_MASK_SHL  = 3'd5,
        OP_MASK_SHR  = 3'd6
    } tcam_op_e;

    // tag encoding is {skip, empty}
    typedef enum logic [1:0] {
        KIND_VALID = 2'b00,
        KIND_EMPTY = 2'b01,
        KIND_SKIP  = 2'b10,
        KIND_RAM   = 2'b11
    } tcam_kind_e;

    typedef enum logic [1:0] {
        AM_ABS   = 2'd0,
        AM_MATCH = 2'd1,
        AM_FREE  = 2'd2,
        AM_NONE  = 2'd3
    } tcam_amode_e;

endpackage

// File: rtl/tcam_seg_mask.sv
`timescale 1ns/1ps
module tcam_seg_mask #(
    parameter  int WIDTH = 64,
    parameter  int SEG_W = 16,
    localparam int NSEG  = WIDTH / SEG_W,
    localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [WIDTH-1:0] field_o
);

    // segment s is compared when s <= sel_i, counting from the low end
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign field_o[s*SEG_W +: SEG_W] = (SEL_W'(s) <= sel_i) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
    end

endmodule

// File: rtl/tcam_match_vec.sv
`timescale 1ns/1ps
module tcam_match_vec #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 64
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] word_i,
    input  logic [DEPTH-1:0][1:0]       kind_i,
    input  logic [WIDTH-1:0]            key_i,
    input  logic [WIDTH-1:0]            care_i,
    input  logic [1:0]                  want_i,
    output logic [DEPTH-1:0]            hit_o
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_line
        assign hit_o[e] = (kind_i[e] == want_i) &&
                          (((word_i[e] ^ key_i) & care_i) == '0);
    end

endmodule

// File: rtl/tcam_prio_enc.sv
`timescale 1ns/1ps
module tcam_prio_enc #(
    parameter  int N  = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic          multi_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    assign any_o   = |req_i;
    assign multi_o = |(req_i & (req_i - N'(1)));

    // R4: the reported index is a requester and none below it requests
    p_grant_is_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[idx_o]);
    p_none_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    // R5: multiple implies at least two requesters
    p_multi_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        multi_o |-> ($countones(req_i) > 1));

endmodule

// File: rtl/tcam_search_core.sv
`timescale 1ns/1ps
module tcam_search_core
    import tcam_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int WIDTH = 64,
    parameter  int SEG_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int NSEG  = WIDTH / SEG_W,
    localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_op,
    input  logic [1:0]       cmd_amode,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [WIDTH-1:0] cmd_data,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_use_mask,
    input  logic [SEL_W-1:0] cmp_segs,
    output logic             match_o,
    output logic             multi_o,
    output logic [AW-1:0]    match_addr_o,
    output logic             full_o,
    output logic [AW-1:0]    free_addr_o
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] word;
        logic [DEPTH-1:0][1:0]       kind;
        logic [WIDTH-1:0]            mask;
        logic [WIDTH-1:0]            key;
        logic                        hit;
        logic                        multi;
        logic [AW-1:0]               hit_addr;
        logic                        full;
        logic [AW-1:0]               free_addr;
    } core_s;

    core_s s_q, s_d;

    tcam_op_e    op;
    tcam_amode_e amode;
    assign op    = tcam_op_e'(cmd_op);
    assign amode = tcam_amode_e'(cmd_amode);

    // ---------------- search path ----------------
    logic [WIDTH-1:0] seg_field;
    logic [WIDTH-1:0] care;
    logic [WIDTH-1:0] key_sel;
    logic [1:0]       want;
    logic [DEPTH-1:0] hit_vec;
    logic             hit_any, hit_multi;
    logic [AW-1:0]    hit_idx;
    logic             is_search;

    tcam_seg_mask #(.WIDTH(WIDTH), .SEG_W(SEG_W)) i_seg (
        .sel_i   (cmp_segs),
        .field_o (seg_field)
    );

    assign is_search = (op == OP_LOAD_KEY) || (op == OP_FORCE);
    assign care      = seg_field & (cmd_use_mask ? ~s_q.mask : {WIDTH{1'b1}});
    assign key_sel   = (op == OP_LOAD_KEY) ? cmd_data : s_q.key;
    assign want      = (op == OP_FORCE) ? cmd_kind : KIND_VALID;

    tcam_match_vec #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_match (
        .word_i (s_q.word),
        .kind_i (s_q.kind),
        .key_i  (key_sel),
        .care_i (care),
        .want_i (want),
        .hit_o  (hit_vec)
    );

    tcam_prio_enc #(.N(DEPTH)) i_hit_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (hit_vec),
        .any_o   (hit_any),
        .multi_o (hit_multi),
        .idx_o   (hit_idx)
    );

    // ---------------- write path ----------------
    logic                    wr_en;
    logic [AW-1:0]           wr_addr;
    logic [WIDTH-1:0]        wr_word;
    logic [DEPTH-1:0][1:0]   kind_nx;
    logic [DEPTH-1:0]        free_req;
    logic                    free_any, free_multi;
    logic [AW-1:0]           free_idx;

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = cmd_addr;
        if (op == OP_WRITE) begin
            unique case (amode)
                AM_ABS:   wr_en = 1'b1;
                AM_MATCH: begin
                    wr_en   = s_q.hit;
                    wr_addr = s_q.hit_addr;
                end
                AM_FREE:  begin
                    wr_en   = !s_q.full;
                    wr_addr = s_q.free_addr;
                end
                default:  wr_en = 1'b0;
            endcase
        end
        wr_word = cmd_use_mask ? ((s_q.word[wr_addr] & s_q.mask) | (cmd_data & ~s_q.mask))
                               : cmd_data;
        kind_nx = s_q.kind;
        if (wr_en) kind_nx[wr_addr] = cmd_kind;
        for (int i = 0; i < DEPTH; i++) begin
            free_req[i] = (kind_nx[i] == KIND_EMPTY);
        end
    end

    tcam_prio_enc #(.N(DEPTH)) i_free_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (free_req),
        .any_o   (free_any),
        .multi_o (free_multi),
        .idx_o   (free_idx)
    );

    // ---------------- next state ----------------
    always_comb begin
        s_d      = s_q;
        s_d.kind = kind_nx;
        if (wr_en) s_d.word[wr_addr] = wr_word;
        s_d.full      = !free_any;
        s_d.free_addr = free_idx;
        unique case (op)
            OP_LOAD_KEY:  s_d.key  = cmd_data;
            OP_LOAD_MASK: s_d.mask = cmd_data;
            OP_MASK_SHL:  s_d.mask = {s_q.mask[WIDTH-2:0], 1'b0};
            OP_MASK_SHR:  s_d.mask = {1'b0, s_q.mask[WIDTH-1:1]};
            default:      ;
        endcase
        if (is_search) begin
            s_d.hit      = hit_any;
            s_d.multi    = hit_multi;
            s_d.hit_addr = hit_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.kind <= {DEPTH{KIND_EMPTY}};
        end else begin
            s_q <= s_d;
        end
    end

    assign match_o      = s_q.hit;
    assign multi_o      = s_q.multi;
    assign match_addr_o = s_q.hit_addr;
    assign full_o       = s_q.full;
    assign free_addr_o  = s_q.free_addr;

    // ---------------- assertions ----------------
    // R7: the free address points at an Empty word, and is zero when full
    p_free_is_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.full |-> (s_q.kind[s_q.free_addr] == KIND_EMPTY));
    p_full_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.full |-> (s_q.free_addr == '0));
    // R8: search results hold when no search is issued
    p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_search |=> ($stable(s_q.hit) && $stable(s_q.multi) && $stable(s_q.hit_addr)));
    // R5: multiple hits imply a hit
    p_multi_has_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.multi |-> s_q.hit);
    // R10: an unmasked enabled write lands in the target word
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cmd_use_mask) |=> (s_q.word[$past(wr_addr)] == $past(cmd_data)));

endmodule

// File: tb/test_tcam_search_core.sv
`timescale 1ns/1ps
module test_tcam_search_core;

    localparam int DEPTH = 64;
    localparam int WIDTH = 64;
    localparam int AW    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [1:0]       cmd_amode = '0;
    logic [AW-1:0]    cmd_addr = '0;
    logic [WIDTH-1:0] cmd_data = '0;
    logic [1:0]       cmd_kind = '0;
    logic             cmd_use_mask = 1'b0;
    logic [1:0]       cmp_segs = 2'd3;
    logic             match_o, multi_o, full_o;
    logic [AW-1:0]    match_addr_o, free_addr_o;

    always #2.5 clk = ~clk;

    tcam_search_core i_tcam_search_core (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_amode(cmd_amode),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_kind(cmd_kind),
        .cmd_use_mask(cmd_use_mask), .cmp_segs(cmp_segs),
        .match_o(match_o), .multi_o(multi_o), .match_addr_o(match_addr_o),
        .full_o(full_o), .free_addr_o(free_addr_o)
    );

    // ---------------- behavioural model ----------------
    logic [WIDTH-1:0] m_word [DEPTH];
    logic [1:0]       m_kind [DEPTH];
    logic [WIDTH-1:0] m_mask, m_key;
    logic             m_hit, m_multi, m_full;
    logic [AW-1:0]    m_addr, m_free;

    typedef struct {
        logic          hit;
        logic          multi;
        logic [AW-1:0] addr;
        logic          full;
        logic [AW-1:0] free;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    exp_t e;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_word[i] = '0;
            m_kind[i] = 2'b01;
        end
        m_mask = '0; m_key = '0; m_hit = 0; m_multi = 0; m_addr = '0;
        m_full = 0; m_free = '0;
    endtask

    task automatic model_search(input logic [WIDTH-1:0] k, input logic [1:0] tgt,
                                input logic um, input logic [1:0] sg);
        logic [WIDTH-1:0] care;
        int cnt;
        care = '0;
        for (int s = 0; s < 4; s++) if (s <= int'(sg)) care[s*16 +: 16] = 16'hFFFF;
        if (um) care = care & ~m_mask;
        cnt = 0;
        m_addr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_kind[i] == tgt && ((m_word[i] ^ k) & care) == '0) begin
                if (cnt == 0) m_addr = AW'(i);
                cnt++;
            end
        end
        m_hit = (cnt > 0);
        m_multi = (cnt > 1);
    endtask

    task automatic model_free();
        m_full = 1; m_free = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (m_kind[i] == 2'b01) begin
                m_full = 0;
                m_free = AW'(i);
            end
        end
    endtask

    // ---------------- driver ----------------
    task automatic do_cmd(input logic [2:0] o, input logic [1:0] am, input logic [AW-1:0] a,
                          input logic [WIDTH-1:0] d, input logic [1:0] t, input logic um,
                          input logic [1:0] sg, input string req);
        exp_t x;
        logic en;
        logic [AW-1:0] wa;
        @(negedge clk);
        cmd_op = o; cmd_amode = am; cmd_addr = a; cmd_data = d;
        cmd_kind = t; cmd_use_mask = um; cmp_segs = sg;
        case (o)
            3'd1: begin
                en = 0; wa = a;
                case (am)
                    2'd0: en = 1;
                    2'd1: begin en = m_hit; wa = m_addr; end
                    2'd2: begin en = !m_full; wa = m_free; end
                    default: en = 0;
                endcase
                if (en) begin
                    m_word[wa] = um ? ((m_word[wa] & m_mask) | (d & ~m_mask)) : d;
                    m_kind[wa] = t;
                end
            end
            3'd2: begin m_key = d; model_search(d, 2'b00, um, sg); end
            3'd3: model_search(m_key, t, um, sg);
            3'd4: m_mask = d;
            3'd5: m_mask = m_mask << 1;
            3'd6: m_mask = m_mask >> 1;
            default: ;
        endcase
        model_free();
        x.hit = m_hit; x.multi = m_multi; x.addr = m_addr;
        x.full = m_full; x.free = m_free; x.req = req;
        @(posedge clk);
        #1;
        exp_q.push_back(x);
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_vec++;
            if (match_o !== e.hit || multi_o !== e.multi || match_addr_o !== e.addr ||
                full_o !== e.full || free_addr_o !== e.free) begin
                n_bad++;
                $display("FAIL %s: got hit=%0b multi=%0b addr=%0d full=%0b free=%0d, expected hit=%0b multi=%0b addr=%0d full=%0b free=%0d",
                         e.req, match_o, multi_o, match_addr_o, full_o, free_addr_o,
                         e.hit, e.multi, e.addr, e.full, e.free);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    localparam logic [WIDTH-1:0] VA = 64'hA5A5_1234_5678_9ABC;
    localparam logic [WIDTH-1:0] VX = 64'h0F0F_0000_CAFE_0001;
    localparam logic [WIDTH-1:0] VB = 64'h1111_2222_3333_4444;
    localparam logic [WIDTH-1:0] VC = 64'h7777_8888_9999_AAAA;
    localparam logic [WIDTH-1:0] VD = 64'hDEAD_BEEF_0BAD_F00D;
    localparam logic [WIDTH-1:0] VE = 64'h0123_4567_89AB_CDEF;

    initial begin
        logic [WIDTH-1:0] pool [4];
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        do_cmd(0, 0, 0, '0, 0, 0, 3, "R9 reset state");
        do_cmd(2, 0, 0, '0, 0, 0, 3, "R9 search of empty table");
        do_cmd(1, 0, 0, VX, 2'b00, 0, 3, "R7 free moves after write");
        do_cmd(1, 0, 5, VA, 2'b00, 0, 3, "R10 absolute write");
        do_cmd(1, 0, 9, VA, 2'b00, 0, 3, "R10 absolute write");
        do_cmd(2, 0, 0, VA, 0, 0, 3, "R4 R5 duplicate hit");
        do_cmd(2, 0, 0, VX, 0, 0, 3, "R4 single hit at 0");
        do_cmd(1, 0, 3, VA, 2'b10, 0, 3, "R1 skip tag");
        do_cmd(2, 0, 0, VA, 0, 0, 3, "R2 skip word ignored");
        do_cmd(3, 0, 0, '0, 2'b10, 0, 3, "R2 forced search of skip");
        do_cmd(1, 0, 7, VA, 2'b11, 0, 3, "R1 ram tag");
        do_cmd(3, 0, 0, '0, 2'b11, 0, 3, "R1 R2 forced search of ram");
        do_cmd(0, 0, 0, '0, 0, 0, 3, "R8 hold on nop");
        do_cmd(1, 0, 12, VB, 2'b00, 0, 3, "R8 hold on write");
        do_cmd(4, 0, 0, 64'h0000_0000_0000_FFFF, 0, 0, 3, "R8 R12 mask load");
        do_cmd(2, 0, 0, VA ^ 64'h1234, 0, 1, 3, "R3 masked bits ignored");
        do_cmd(2, 0, 0, VA ^ 64'h1234, 0, 0, 3, "R3 unmasked miss");
        do_cmd(5, 0, 0, '0, 0, 0, 3, "R12 shift left");
        do_cmd(2, 0, 0, VA ^ 64'h1, 0, 1, 3, "R12 bit0 cared after shl");
        do_cmd(2, 0, 0, VA ^ 64'h1_0000, 0, 1, 3, "R12 bit16 masked after shl");
        do_cmd(6, 0, 0, '0, 0, 0, 3, "R12 shift right");
        do_cmd(6, 0, 0, '0, 0, 0, 3, "R12 shift right");
        do_cmd(2, 0, 0, VA ^ 64'h4000, 0, 1, 3, "R12 bit14 masked");
        do_cmd(2, 0, 0, VA ^ 64'h8000, 0, 1, 3, "R12 bit15 cared after shr");
        do_cmd(2, 0, 0, VA ^ (64'h1 << 40), 0, 0, 1, "R6 upper segment ignored");
        do_cmd(2, 0, 0, VA ^ (64'h1 << 40), 0, 0, 2, "R6 third segment compared");
        do_cmd(2, 0, 0, VA ^ (64'h1 << 63), 0, 0, 2, "R6 top bit ignored");
        do_cmd(2, 0, 0, VA ^ (64'h1 << 63), 0, 0, 3, "R6 top bit compared");
        do_cmd(2, 0, 0, VA, 0, 0, 3, "R4 hit before write");
        do_cmd(1, 1, 0, VB, 2'b00, 1, 3, "R11 masked write to hit");
        do_cmd(2, 0, 0, (VA & 64'h7FFF) | (VB & ~64'h7FFF), 0, 0, 3, "R11 merged word");
        do_cmd(2, 0, 0, VC, 0, 0, 3, "R10 miss before write");
        do_cmd(1, 1, 0, VC, 2'b00, 0, 3, "R10 hit-address write ignored");
        do_cmd(2, 0, 0, VC, 0, 0, 3, "R10 ignored write absent");
        do_cmd(1, 3, 4, VC, 2'b00, 0, 3, "R10 mode 3 writes nothing");
        do_cmd(2, 0, 0, VC, 0, 0, 3, "R10 mode 3 absent");
        do_cmd(1, 2, 0, VD, 2'b00, 0, 3, "R10 free write");
        do_cmd(2, 0, 0, VD, 0, 0, 3, "R10 free write landed");
        for (int i = 0; i < DEPTH; i++) begin
            do_cmd(1, 2, 0, VC ^ WIDTH'(i), 2'b10, 0, 3, "R7 fill");
        end
        do_cmd(1, 2, 0, VE, 2'b00, 0, 3, "R7 full write ignored");
        do_cmd(2, 0, 0, VE, 0, 0, 3, "R7 full write absent");
        do_cmd(1, 0, 20, '0, 2'b01, 0, 3, "R7 free after release");
        do_cmd(1, 0, 11, '0, 2'b01, 0, 3, "R7 lower free wins");

        pool[0] = VA; pool[1] = VB; pool[2] = VD; pool[3] = VX;
        for (int k = 0; k < 600; k++) begin
            int r;
            logic [WIDTH-1:0] d;
            logic [1:0] t;
            r = $urandom_range(0, 9);
            d = pool[$urandom_range(0, 3)];
            if ($urandom_range(0, 1) == 1) d = d ^ (WIDTH'(1) << $urandom_range(0, 63));
            t = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
            if (r < 4)
                do_cmd(1, 2'($urandom_range(0, 2)), AW'($urandom), d, t, 1'($urandom),
                       2'($urandom), "R10 R11 random write");
            else if (r < 7)
                do_cmd(2, 0, 0, d, 0, 1'($urandom), 2'($urandom), "R3 R4 R5 R6 random search");
            else if (r == 7)
                do_cmd(3, 0, 0, '0, 2'($urandom), 1'($urandom), 2'($urandom), "R2 random forced");
            else if (r == 8)
                do_cmd(4, 0, 0, {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom},
                       0, 0, 3, "R12 random mask");
            else
                do_cmd(3'($urandom_range(5, 6)), 0, 0, '0, 0, 0, 3, "R12 R8 random shift");
        end

        repeat (3) @(posedge clk);
        done = 1;
        finish_run();
    end

endmodule